// File: doc/BRIEF.md
# Generic Address Space Window Decoder

This block sits beside a shader core's memory pipeline. For each access it decides which space the access targets: per-thread local memory, per-workgroup shared memory, or global virtual memory. It also produces the address to use inside that space. The generic address space is 64 bits wide. Two 16MB windows are carved out of it, one for local memory and one for shared memory. Software places each window by writing its base through a small register write port. Both windows must lie below 4GB and start on a 16MB boundary.

Generic accesses are compared against the two windows. These are loads, stores, reductions, atomics and cache-control operations. An address that falls inside a window becomes a 24-bit offset into that space. Every other address goes to global memory unchanged. Direct local and direct shared instructions skip the comparison. Graphics work has no shared space, so a mode input turns shared-window matching off.

Requests enter through a valid/ready handshake. The decoded result appears one cycle after acceptance and is held until the consumer takes it.

Top module: `gas_window_decoder`

## Requirements
- R1: After reset, rsp_valid_o and err_o are 0, req_ready_o is 1, and both window bases are 0. A generic access below 0x0100_0000 therefore decodes as local.
- R2: A generic access hits the local window when addr[63:32] is zero and addr[31:24] equals bits [31:24] of the local base. The result is space 2'b01, with rsp_addr_o equal to addr[23:0] zero-extended to 64 bits.
- R3: In compute mode (req_gfx_i=0), a generic access hits the shared window under the same rule applied to the shared base. The result is space 2'b10 with the zero-extended 24-bit offset.
- R4: In graphics mode (req_gfx_i=1), the shared window never matches. Such an address decodes as global.
- R5: A generic access that hits no window decodes as space 2'b00 with rsp_addr_o equal to the full 64-bit input address. This includes any address with a nonzero bit in [63:32].
- R6: The direct-local class (3'd5) always gives space 2'b01 and the direct-shared class (3'd6) always gives space 2'b10. In both cases rsp_addr_o is addr[23:0] zero-extended, whatever the window bases and the mode.
- R7: When both window bases are equal, an address inside them decodes as local.
- R8: A write whose data is to be used as a window base must have bits [23:0] zero. The local base is at offset 12'h77c and the shared base at 12'h214. A write to either offset with any of those bits nonzero leaves that base unchanged and sets err_o on the next cycle.
- R9: err_o stays set until a cycle with err_rd_i=1, and reads 0 on the cycle after that. If a rejected write arrives in the same cycle as err_rd_i, the set wins.
- R10: A write to any offset other than 12'h77c and 12'h214 changes neither window base and does not set err_o.
- R11: An accepted request (req_valid_i and req_ready_o high at a clock edge) produces rsp_valid_o on the next cycle. While rsp_valid_o=1 and rsp_ready_i=0, the response stays unchanged and req_ready_o is 0.
- R12: The classes load (3'd0), store (3'd1), reduction (3'd2), atomic (3'd3), cache control (3'd4) and reserved (3'd7) are all decoded against the windows in the same way.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| cfg_we_i | input | 1 | Register write strobe |
| cfg_addr_i | input | 12 | Register write offset |
| cfg_wdata_i | input | 32 | Register write data (window base byte address) |
| err_rd_i | input | 1 | Read of the error flag; clears it |
| err_o | output | 1 | Sticky misaligned-base-write flag |
| req_valid_i | input | 1 | Request valid |
| req_ready_o | output | 1 | Request accepted when high with valid |
| req_class_i | input | 3 | Access class |
| req_addr_i | input | 64 | Generic or direct address |
| req_gfx_i | input | 1 | 1 for graphics work, 0 for compute |
| rsp_valid_o | output | 1 | Decoded result valid |
| rsp_ready_i | input | 1 | Consumer takes the result |
| rsp_space_o | output | 2 | 00 global, 01 local, 10 shared |
| rsp_addr_o | output | 64 | In-window offset, or full address for global |

## Verification
The hardest cases to reach from the ports are the ones that need the register state and the request stream to line up. One is a rejected base write that lands in the same cycle as a flag read. Another is a pair of windows placed on the same base, and a third is a response held while the consumer stalls and a new request waits. The stimulus first moves the windows away from their reset position. It then sends addresses one below, at the top of, and one past each window, plus an address that matches a window only in bits [31:24]. It drives err_rd_i and a misaligned write together in one cycle, and lowers rsp_ready_i across several cycles with a request waiting behind the held response.

// File: rtl/gas_pkg.sv
package gas_pkg;
  typedef enum logic [1:0] {
    SP_GLOBAL = 2'b00,
    SP_LOCAL  = 2'b01,
    SP_SHARED = 2'b10
  } space_e;

  typedef enum logic [2:0] {
    AC_LOAD    = 3'd0,
    AC_STORE   = 3'd1,
    AC_RED     = 3'd2,
    AC_ATOM    = 3'd3,
    AC_CCTL    = 3'd4,
    AC_DLOCAL  = 3'd5,
    AC_DSHARED = 3'd6,
    AC_RSVD    = 3'd7
  } acc_e;
endpackage

// File: rtl/gas_win_reg.sv
module gas_win_reg #(
  parameter int unsigned CFG_AW = 12,
  parameter int unsigned BASE_W = 32,
  parameter int unsigned WIN_W  = 24,
  parameter logic [CFG_AW-1:0] OFS = '0
) (
  input  logic                    clk_i,
  input  logic                    rst_ni,
  input  logic                    we_i,
  input  logic [CFG_AW-1:0]       addr_i,
  input  logic [BASE_W-1:0]       wdata_i,
  output logic [BASE_W-WIN_W-1:0] tag_o,
  output logic                    bad_o
);
  logic hit;
  logic aligned;

  assign hit     = we_i && (addr_i == OFS);
  assign aligned = ~|wdata_i[WIN_W-1:0];
  assign bad_o   = hit && !aligned;

  // only the window-select bits are stored; low bits are zero by rule
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)             tag_o <= '0;
    else if (hit && aligned) tag_o <= wdata_i[BASE_W-1:WIN_W];
  end
endmodule

// File: rtl/gas_classify.sv
module gas_classify
  import gas_pkg::*;
#(
  parameter int unsigned ADDR_W = 64,
  parameter int unsigned BASE_W = 32,
  parameter int unsigned WIN_W  = 24
) (
  input  logic [2:0]              cls_i,
  input  logic [ADDR_W-1:0]       addr_i,
  input  logic                    gfx_i,
  input  logic [BASE_W-WIN_W-1:0] ltag_i,
  input  logic [BASE_W-WIN_W-1:0] stag_i,
  output logic [1:0]              space_o,
  output logic [ADDR_W-1:0]       addr_o
);
  logic              low4g;
  logic              l_hit;
  logic              s_hit;
  logic [ADDR_W-1:0] offs;

  assign low4g = ~|addr_i[ADDR_W-1:BASE_W];
  assign l_hit = low4g && (addr_i[BASE_W-1:WIN_W] == ltag_i);
  assign s_hit = low4g && !gfx_i && (addr_i[BASE_W-1:WIN_W] == stag_i);
  assign offs  = {{(ADDR_W-WIN_W){1'b0}}, addr_i[WIN_W-1:0]};

  always_comb begin
    space_o = SP_GLOBAL;
    addr_o  = addr_i;
    unique case (acc_e'(cls_i))
      AC_DLOCAL: begin
        space_o = SP_LOCAL;
        addr_o  = offs;
      end
      AC_DSHARED: begin
        space_o = SP_SHARED;
        addr_o  = offs;
      end
      default: begin
        // local has priority over shared on overlap
        if (l_hit) begin
          space_o = SP_LOCAL;
          addr_o  = offs;
        end else if (s_hit) begin
          space_o = SP_SHARED;
          addr_o  = offs;
        end
      end
    endcase
  end
endmodule

// File: rtl/gas_out_stage.sv
module gas_out_stage #(
  parameter int unsigned ADDR_W = 64
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              in_valid_i,
  output logic              in_ready_o,
  input  logic [1:0]        in_space_i,
  input  logic [ADDR_W-1:0] in_addr_i,
  output logic              out_valid_o,
  input  logic              out_ready_i,
  output logic [1:0]        out_space_o,
  output logic [ADDR_W-1:0] out_addr_o
);
  logic load;

  assign in_ready_o = !out_valid_o || out_ready_i;
  assign load       = in_valid_i && in_ready_o;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)          out_valid_o <= 1'b0;
    else if (in_ready_o)  out_valid_o <= in_valid_i;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      out_space_o <= '0;
      out_addr_o  <= '0;
    end else if (load) begin
      out_space_o <= in_space_i;
      out_addr_o  <= in_addr_i;
    end
  end
endmodule

// File: rtl/gas_window_decoder.sv
module gas_window_decoder #(
  parameter int unsigned ADDR_W = 64,
  parameter int unsigned BASE_W = 32,
  parameter int unsigned WIN_W  = 24,
  parameter int unsigned CFG_AW = 12,
  parameter logic [CFG_AW-1:0] LOCAL_OFS  = 12'h77c,
  parameter logic [CFG_AW-1:0] SHARED_OFS = 12'h214
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              cfg_we_i,
  input  logic [CFG_AW-1:0] cfg_addr_i,
  input  logic [BASE_W-1:0] cfg_wdata_i,
  input  logic              err_rd_i,
  output logic              err_o,
  input  logic              req_valid_i,
  output logic              req_ready_o,
  input  logic [2:0]        req_class_i,
  input  logic [ADDR_W-1:0] req_addr_i,
  input  logic              req_gfx_i,
  output logic              rsp_valid_o,
  input  logic              rsp_ready_i,
  output logic [1:0]        rsp_space_o,
  output logic [ADDR_W-1:0] rsp_addr_o
);
  localparam int unsigned TAG_W = BASE_W - WIN_W;
  localparam int unsigned N_WIN = 2;

  logic [N_WIN-1:0][TAG_W-1:0] tag;
  logic [N_WIN-1:0]            bad;
  logic [1:0]                  dec_space;
  logic [ADDR_W-1:0]           dec_addr;

  // window 0 = local, window 1 = shared
  for (genvar w = 0; w < N_WIN; w++) begin : g_win
    localparam logic [CFG_AW-1:0] OFS = (w == 0) ? LOCAL_OFS : SHARED_OFS;
    gas_win_reg #(
      .CFG_AW(CFG_AW), .BASE_W(BASE_W), .WIN_W(WIN_W), .OFS(OFS)
    ) u_reg (
      .clk_i  (clk_i),
      .rst_ni (rst_ni),
      .we_i   (cfg_we_i),
      .addr_i (cfg_addr_i),
      .wdata_i(cfg_wdata_i),
      .tag_o  (tag[w]),
      .bad_o  (bad[w])
    );
  end

  // set beats clear
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)       err_o <= 1'b0;
    else if (|bad)     err_o <= 1'b1;
    else if (err_rd_i) err_o <= 1'b0;
  end

  gas_classify #(
    .ADDR_W(ADDR_W), .BASE_W(BASE_W), .WIN_W(WIN_W)
  ) u_cls (
    .cls_i  (req_class_i),
    .addr_i (req_addr_i),
    .gfx_i  (req_gfx_i),
    .ltag_i (tag[0]),
    .stag_i (tag[1]),
    .space_o(dec_space),
    .addr_o (dec_addr)
  );

  gas_out_stage #(.ADDR_W(ADDR_W)) u_out (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .in_valid_i (req_valid_i),
    .in_ready_o (req_ready_o),
    .in_space_i (dec_space),
    .in_addr_i  (dec_addr),
    .out_valid_o(rsp_valid_o),
    .out_ready_i(rsp_ready_i),
    .out_space_o(rsp_space_o),
    .out_addr_o (rsp_addr_o)
  );
endmodule

// File: rtl/gas_window_decoder_chk.sv
module gas_window_decoder_chk #(
  parameter int unsigned ADDR_W = 64,
  parameter int unsigned BASE_W = 32,
  parameter int unsigned WIN_W  = 24,
  parameter int unsigned CFG_AW = 12,
  parameter logic [CFG_AW-1:0] LOCAL_OFS  = 12'h77c,
  parameter logic [CFG_AW-1:0] SHARED_OFS = 12'h214
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              cfg_we_i,
  input logic [CFG_AW-1:0] cfg_addr_i,
  input logic [BASE_W-1:0] cfg_wdata_i,
  input logic              err_rd_i,
  input logic              err_o,
  input logic              req_valid_i,
  input logic              req_ready_o,
  input logic [2:0]        req_class_i,
  input logic [ADDR_W-1:0] req_addr_i,
  input logic              req_gfx_i,
  input logic              rsp_valid_o,
  input logic              rsp_ready_i,
  input logic [1:0]        rsp_space_o,
  input logic [ADDR_W-1:0] rsp_addr_o
);
  logic bad_wr;
  logic acc;

  assign bad_wr = cfg_we_i && ((cfg_addr_i == LOCAL_OFS) || (cfg_addr_i == SHARED_OFS))
                  && (|cfg_wdata_i[WIN_W-1:0]);
  assign acc    = req_valid_i && req_ready_o;

  a_r11_latency: assert property (@(posedge clk_i) disable iff (!rst_ni)
    acc |=> rsp_valid_o);

  a_r11_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rsp_valid_o && !rsp_ready_i |=> rsp_valid_o && $stable(rsp_space_o) && $stable(rsp_addr_o));

  a_r11_stall_ready: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rsp_valid_o && !rsp_ready_i |-> !req_ready_o);

  a_r2_offset_width: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rsp_valid_o && (rsp_space_o != 2'b00) |-> rsp_addr_o[ADDR_W-1:WIN_W] == '0);

  a_r2_space_legal: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rsp_valid_o |-> rsp_space_o != 2'b11);

  a_r8_set: assert property (@(posedge clk_i) disable iff (!rst_ni)
    bad_wr |=> err_o);

  a_r8_cause: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(err_o) |-> $past(bad_wr));

  a_r9_clear: assert property (@(posedge clk_i) disable iff (!rst_ni)
    err_rd_i && !bad_wr |=> !err_o);

  a_r4_no_shared_gfx: assert property (@(posedge clk_i) disable iff (!rst_ni)
    acc && req_gfx_i && (req_class_i != 3'd6) |=> rsp_space_o != 2'b10);

  a_r6_direct_local: assert property (@(posedge clk_i) disable iff (!rst_ni)
    acc && (req_class_i == 3'd5) |=> (rsp_space_o == 2'b01) && (rsp_addr_o[ADDR_W-1:WIN_W] == '0));

  a_r6_direct_shared: assert property (@(posedge clk_i) disable iff (!rst_ni)
    acc && (req_class_i == 3'd6) |=> rsp_space_o == 2'b10);
endmodule

bind gas_window_decoder gas_window_decoder_chk u_chk (.*);

// File: tb/sim_gas_window_decoder.sv
`timescale 1ns/1ps
module sim_gas_window_decoder;
  localparam time TCK = 20ns;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cfg_we = 1'b0;
  logic [11:0] cfg_addr = '0;
  logic [31:0] cfg_wdata = '0;
  logic        err_rd = 1'b0;
  logic        err_o;
  logic        req_valid = 1'b0;
  logic        req_ready_o;
  logic [2:0]  req_class = '0;
  logic [63:0] req_addr = '0;
  logic        req_gfx = 1'b0;
  logic        rsp_valid_o;
  logic        rsp_ready = 1'b1;
  logic [1:0]  rsp_space_o;
  logic [63:0] rsp_addr_o;

  always #(TCK/2) clk = ~clk;

  gas_window_decoder u0 (
    .clk_i(clk), .rst_ni(rst_n),
    .cfg_we_i(cfg_we), .cfg_addr_i(cfg_addr), .cfg_wdata_i(cfg_wdata),
    .err_rd_i(err_rd), .err_o(err_o),
    .req_valid_i(req_valid), .req_ready_o(req_ready_o),
    .req_class_i(req_class), .req_addr_i(req_addr), .req_gfx_i(req_gfx),
    .rsp_valid_o(rsp_valid_o), .rsp_ready_i(rsp_ready),
    .rsp_space_o(rsp_space_o), .rsp_addr_o(rsp_addr_o)
  );

  typedef struct packed {
    logic [1:0]  sp;
    logic [63:0] ad;
    logic [7:0]  rq;
  } exp_t;

  exp_t sbq[$];
  int   n_chk = 0;
  int   n_fail = 0;
  logic [7:0] mdl_l = 8'h00;
  logic [7:0] mdl_s = 8'h00;

  task automatic chk(input bit ok, input int rq, input string what,
                     input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL R%0d %s: actual %h expected %h", rq, what, act, exp);
    end
  endtask

  // expectation from the requirement text
  function automatic exp_t model(input logic [2:0] c, input logic [63:0] a,
                                 input logic g, input logic [7:0] rq);
    exp_t e;
    logic [63:0] off;
    off  = {40'h0, a[23:0]};
    e.rq = rq;
    e.sp = 2'b00;
    e.ad = a;
    if (c == 3'd5)      begin e.sp = 2'b01; e.ad = off; end
    else if (c == 3'd6) begin e.sp = 2'b10; e.ad = off; end
    else if (a[63:32] == 32'h0 && a[31:24] == mdl_l) begin e.sp = 2'b01; e.ad = off; end
    else if (a[63:32] == 32'h0 && a[31:24] == mdl_s && !g) begin e.sp = 2'b10; e.ad = off; end
    return e;
  endfunction

  // monitor: a response seen valid with ready high transfers at the next edge
  always @(negedge clk) begin
    if (rst_n && rsp_valid_o && rsp_ready) begin
      if (sbq.size() == 0) begin
        chk(1'b0, 11, "unexpected response", rsp_addr_o, 64'h0);
      end else begin
        exp_t e;
        e = sbq.pop_front();
        chk(rsp_space_o == e.sp, int'(e.rq), "space", {62'h0, rsp_space_o}, {62'h0, e.sp});
        chk(rsp_addr_o == e.ad, int'(e.rq), "addr", rsp_addr_o, e.ad);
      end
    end
  end

  task automatic send(input logic [2:0] c, input logic [63:0] a, input logic g, input logic [7:0] rq);
    exp_t e;
    logic rdy;
    e = model(c, a, g, rq);
    @(posedge clk); #2;
    req_valid = 1'b1; req_class = c; req_addr = a; req_gfx = g;
    forever begin
      @(negedge clk) rdy = req_ready_o;
      @(posedge clk);
      if (rdy) begin sbq.push_back(e); break; end
    end
    #2 req_valid = 1'b0;
    @(negedge clk);
    chk(rsp_valid_o == 1'b1, 11, "valid one cycle after accept", {63'h0, rsp_valid_o}, 64'h1); // R11
  endtask

  task automatic cfg_wr(input logic [11:0] ofs, input logic [31:0] d);
    @(posedge clk); #2;
    cfg_we = 1'b1; cfg_addr = ofs; cfg_wdata = d;
    @(posedge clk);
    if (d[23:0] == 24'h0) begin
      if (ofs == 12'h77c) mdl_l = d[31:24];
      if (ofs == 12'h214) mdl_s = d[31:24];
    end
    #2 cfg_we = 1'b0;
    @(negedge clk);
  endtask

  task automatic summary;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
  endtask

  initial begin
    #(TCK * 150000);
    n_fail++;
    $display("FAIL watchdog expired");
    summary();
    $finish;
  end

  initial begin
    logic [63:0] held;
    repeat (3) @(posedge clk);
    #2 rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    chk(rsp_valid_o == 1'b0, 1, "rsp_valid after reset", {63'h0, rsp_valid_o}, 64'h0);
    chk(err_o == 1'b0, 1, "err after reset", {63'h0, err_o}, 64'h0);
    chk(req_ready_o == 1'b1, 1, "ready after reset", {63'h0, req_ready_o}, 64'h1);
    // R1 and R7: both bases 0, bottom 16MB is local
    send(3'd0, 64'h0000_0000_00AB_CDEF, 1'b0, 8'd1);

    cfg_wr(12'h77c, 32'h3000_0000);
    cfg_wr(12'h214, 32'h5000_0000);
    chk(err_o == 1'b0, 8, "aligned writes leave err clear", {63'h0, err_o}, 64'h0);

    // R12 and R2: every generic class decodes the same
    foreach (sbq[i]) ; // no-op keeps the queue type in use
    for (int k = 0; k < 6; k++) begin
      logic [2:0] c;
      c = (k == 5) ? 3'd7 : 3'(k);
      send(c, 64'h0000_0000_3012_3456, 1'b0, 8'd12);
      send(c, 64'h0000_0000_5000_0001, 1'b0, 8'd12);
    end
    // R2 window edges
    send(3'd1, 64'h0000_0000_3000_0000, 1'b0, 8'd2);
    send(3'd1, 64'h0000_0000_30FF_FFFF, 1'b0, 8'd2);
    // R3 shared top, R5 one past and one below
    send(3'd0, 64'h0000_0000_50FF_FFFF, 1'b0, 8'd3);
    send(3'd0, 64'h0000_0000_5100_0000, 1'b0, 8'd5);
    send(3'd0, 64'h0000_0000_4FFF_FFFF, 1'b0, 8'd5);
    // R5 upper bits set but [31:24] match
    send(3'd3, 64'h0000_0001_3000_0000, 1'b0, 8'd5);
    send(3'd3, 64'h8000_0000_5012_3456, 1'b0, 8'd5);
    // R4 graphics: shared goes global, local still local
    send(3'd0, 64'h0000_0000_5012_3456, 1'b1, 8'd4);
    send(3'd2, 64'h0000_0000_3000_0044, 1'b1, 8'd4);
    // R6 direct classes ignore windows and mode
    send(3'd5, 64'h0000_0000_5012_0000, 1'b1, 8'd6);
    send(3'd6, 64'hFFFF_FFFF_FF00_0001, 1'b1, 8'd6);
    send(3'd6, 64'h0000_0000_3000_0010, 1'b0, 8'd6);

    // R8 misaligned write rejected
    cfg_wr(12'h77c, 32'h6000_0010);
    chk(err_o == 1'b1, 8, "err after misaligned write", {63'h0, err_o}, 64'h1);
    send(3'd0, 64'h0000_0000_3000_0001, 1'b0, 8'd8);
    send(3'd0, 64'h0000_0000_6000_0000, 1'b0, 8'd8);
    // R9 stays set, then read clears
    repeat (2) @(negedge clk);
    chk(err_o == 1'b1, 9, "err sticky", {63'h0, err_o}, 64'h1);
    @(posedge clk); #2 err_rd = 1'b1;
    @(posedge clk); #2 err_rd = 1'b0;
    @(negedge clk);
    chk(err_o == 1'b0, 9, "err cleared by read", {63'h0, err_o}, 64'h0);
    // R9 set wins over read
    @(posedge clk); #2;
    err_rd = 1'b1; cfg_we = 1'b1; cfg_addr = 12'h214; cfg_wdata = 32'h7000_0001;
    @(posedge clk); #2;
    err_rd = 1'b0; cfg_we = 1'b0;
    @(negedge clk);
    chk(err_o == 1'b1, 9, "set wins over read", {63'h0, err_o}, 64'h1);
    send(3'd0, 64'h0000_0000_5000_0002, 1'b0, 8'd8);
    @(posedge clk); #2 err_rd = 1'b1;
    @(posedge clk); #2 err_rd = 1'b0;
    @(negedge clk);
    chk(err_o == 1'b0, 9, "err cleared again", {63'h0, err_o}, 64'h0);

    // R10 other offset ignored
    cfg_wr(12'h100, 32'h7000_0000);
    cfg_wr(12'h77d, 32'h7000_0005);
    chk(err_o == 1'b0, 10, "no err for other offsets", {63'h0, err_o}, 64'h0);
    send(3'd0, 64'h0000_0000_7000_0000, 1'b0, 8'd10);
    send(3'd0, 64'h0000_0000_3000_0000, 1'b0, 8'd10);

    // R7 equal bases
    cfg_wr(12'h214, 32'h3000_0000);
    send(3'd4, 64'h0000_0000_3055_0000, 1'b0, 8'd7);
    send(3'd4, 64'h0000_0000_5055_0000, 1'b0, 8'd7);

    // R11 stall holds the response and blocks new requests
    @(posedge clk); #2 rsp_ready = 1'b0;
    send(3'd0, 64'h0000_0000_3000_0ABC, 1'b0, 8'd11);
    held = rsp_addr_o;
    for (int k = 0; k < 3; k++) begin
      @(negedge clk);
      chk(rsp_valid_o == 1'b1, 11, "valid held in stall", {63'h0, rsp_valid_o}, 64'h1);
      chk(rsp_addr_o == held, 11, "addr held in stall", rsp_addr_o, held);
      chk(req_ready_o == 1'b0, 11, "ready low in stall", {63'h0, req_ready_o}, 64'h0);
    end
    @(posedge clk); #2 rsp_ready = 1'b1;
    send(3'd0, 64'h0000_0000_0000_0001, 1'b0, 8'd11);

    repeat (3) @(negedge clk);
    chk(sbq.size() == 0, 11, "all responses delivered", 64'(sbq.size()), 64'h0);
    summary();
    $finish;
  end
endmodule